// File: doc/BRIEF.md
# Keyed Watchdog Timer with Pretimeout Interrupt

A 16-bit register-mapped watchdog. Software starts the countdown by setting a sticky enable bit, then keeps the system alive by writing an ordered pair of key words to a service register. If the countdown runs out, the block pulses a one-clock reset request and records the cause. A software-triggered reset, requested through an active-low control bit, is recorded the same way. A second threshold raises a pretimeout interrupt some time before expiry, so that firmware can react before the reset is requested.

The countdown advances on a prescaled tick input that pulses once per half second. A timeout field of value T gives T+1 ticks. Several control fields are write-once: the suspend, debug and wait-disable bits freeze after the first control write, and the interrupt enable and pretimeout count freeze after the first interrupt-control write. The enable bit and the timeout-assertion bit can be set but never cleared by software. The counter holds its value while the enable bit is 0, or while the stored suspend bit is set and the external halt input is high.

Register offsets (byte addresses on `bus_addr`): control 0x0, service 0x2, reset cause 0x4, interrupt control 0x6, misc 0x8. Any other address, including odd ones, reads 0 and ignores writes. Reads are combinational from `bus_addr`. Writes take effect at the rising clock edge where `bus_we` is high.

Top module: `kwdt_top`

## Requirements
- R1: After reset, the control register reads 0x0030, interrupt control reads 0x0004, reset cause and misc read 0x0000, and `irq_o` and `rst_req_o` are 0. The service register and unmapped or odd addresses always read 0x0000.
- R2: Control layout: [15:8] timeout T, bit 7 wait-disable, bit 5 assertion-output, bit 4 software-reset (active low, always reads 1), bit 3 timeout-assertion, bit 2 enable, bit 1 debug, bit 0 suspend, bit 6 reads 0. Bits 7, 1 and 0 take the value of the first control write and then ignore later writes. Bits [15:8] and 5 stay writable.
- R3: Once the enable bit (control bit 2) or the timeout-assertion bit (control bit 3) reads 1, writing 0 to it leaves it at 1 until reset.
- R4: Writing the enable bit from 0 to 1 loads the counter with T+1. Each counted tick decrements it. The tick that takes it from 1 to 0 makes `rst_req_o` high for exactly the next clock cycle, sets the reset-cause register to 0x0002 (bit 1 = timeout), and reloads the counter with T+1.
- R5: Writing 0x5555 to the service register and then 0xAAAA as the very next service write reloads the counter with T+1. Any other value written to the service register between the two cancels the sequence, and the following 0xAAAA does not reload.
- R6: Interrupt-control layout: bit 15 interrupt enable, bit 14 status, [7:0] pretimeout count P, other bits read 0. When a counted tick leaves the counter at P and the interrupt enable is 1, the status is set. `irq_o` equals status AND enable.
- R7: Writing 1 to interrupt-control bit 14 clears the status. Writing 0 there leaves it unchanged.
- R8: Bits 15 and [7:0] of interrupt control take the value of the first write to that register and then ignore later writes.
- R9: A control write with bit 4 = 0 makes `rst_req_o` high for the next clock cycle and sets the reset-cause register to 0x0001 (bit 0 = software).
- R10: The counter does not move on ticks while the enable bit is 0, or while suspend (control bit 0) is 1 and `halt_i` is high.
- R11: Misc bit 0 (power-down enable) stores the written value. Misc bits [15:1] read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| tick_i | input | 1 | Prescaled half-second tick, one clock wide |
| halt_i | input | 1 | Suspend request, effective when control bit 0 is set |
| irq_o | output | 1 | Pretimeout interrupt |
| rst_req_o | output | 1 | One-clock reset request |

## Verification
The bench counts ticks across the expiry boundary. A design that reloaded with T instead of T+1, or that fired one tick early, would show a reset request one tick before the expected one. It breaks the key pair with a foreign word and checks that expiry still comes on time; a detector that only watched for 0xAAAA would reload the counter and hide the expiry. It writes conflicting values into the locked fields and checks that the first values remain; a missing lock would change them. It also clears the interrupt status with a word whose enable and count bits are 0, so a lock that failed to guard the interrupt-control register would turn the enable off.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] OFS_CTL   = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_SVC   = 4'h2;
    localparam logic [ADDR_W-1:0] OFS_CAUSE = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_IRQ   = 4'h6;
    localparam logic [ADDR_W-1:0] OFS_MISC  = 4'h8;

    localparam logic [DATA_W-1:0] KEY_ARM  = 16'h5555;
    localparam logic [DATA_W-1:0] KEY_FIRE = 16'hAAAA;

    typedef struct packed {
        logic [7:0] wt;
        logic       wait_off;
        logic       rsv6;
        logic       assert_out;
        logic       swrst_n;
        logic       tout_assert;
        logic       en;
        logic       dbg;
        logic       susp;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{wt: 8'h00, wait_off: 1'b0, rsv6: 1'b0,
                                   assert_out: 1'b1, swrst_n: 1'b1,
                                   tout_assert: 1'b0, en: 1'b0, dbg: 1'b0,
                                   susp: 1'b0};

    typedef enum logic [2:0] {
        SEL_CTL, SEL_SVC, SEL_CAUSE, SEL_IRQ, SEL_MISC, SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_CTL:   return SEL_CTL;
            OFS_SVC:   return SEL_SVC;
            OFS_CAUSE: return SEL_CAUSE;
            OFS_IRQ:   return SEL_IRQ;
            OFS_MISC:  return SEL_MISC;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq
    import kwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              svc_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              reload
);

    logic armed_q;

    // any service write re-decides the armed state; only the arm word keeps it set
    always_ff @(posedge clk) begin
        if (rst)
            armed_q <= 1'b0;
        else if (svc_wr)
            armed_q <= (wdata == KEY_ARM);
    end

    assign reload = svc_wr && armed_q && (wdata == KEY_FIRE);

    // R5
    key_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        reload |=> !armed_q);

endmodule

// File: rtl/kwdt_count.sv
module kwdt_count #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] pre_val,
    output logic          hit,
    output logic          expire
);

    localparam int CNT_W = CW + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] full;
    logic             step;

    assign full   = CNT_W'(load_val) + CNT_W'(1);
    assign step   = run && tick && !load && (cnt_q != '0);
    assign expire = step && (cnt_q == CNT_W'(1));
    assign hit    = step && ((cnt_q - CNT_W'(1)) == CNT_W'(pre_val));

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= full;
        else if (expire)
            cnt_q <= full;
        else if (step)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(cnt_q));

    // R4
    expire_reload_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> (cnt_q == CNT_W'($past(load_val)) + CNT_W'(1)));

endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int          CW      = 8,
    parameter logic [CW-1:0] PRE_DEF = 8'd4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctl,
    input  logic              wr_irq,
    input  logic              wr_misc,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hit,
    input  logic              expire,
    output ctl_t              ctl,
    output logic              sw_req,
    output logic              irq_en,
    output logic              irq_sts,
    output logic [CW-1:0]     pre_val,
    output logic              pd_en,
    output logic [1:0]        cause
);

    ctl_t ctl_new;
    logic ctl_lk;
    logic irq_lk;

    assign ctl_new = ctl_t'(wdata);
    assign sw_req  = wr_ctl && !ctl_new.swrst_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl    <= CTL_RESET;
            ctl_lk <= 1'b0;
        end else if (wr_ctl) begin
            ctl.wt          <= ctl_new.wt;
            ctl.assert_out  <= ctl_new.assert_out;
            ctl.tout_assert <= ctl.tout_assert | ctl_new.tout_assert;
            ctl.en          <= ctl.en | ctl_new.en;
            if (!ctl_lk) begin
                ctl.wait_off <= ctl_new.wait_off;
                ctl.dbg      <= ctl_new.dbg;
                ctl.susp     <= ctl_new.susp;
            end
            ctl_lk <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en  <= 1'b0;
            pre_val <= PRE_DEF;
            irq_lk  <= 1'b0;
        end else if (wr_irq && !irq_lk) begin
            irq_en  <= wdata[15];
            pre_val <= wdata[CW-1:0];
            irq_lk  <= 1'b1;
        end
    end

    // a new pretimeout event wins over a simultaneous clear
    always_ff @(posedge clk) begin
        if (rst)
            irq_sts <= 1'b0;
        else if (hit && irq_en)
            irq_sts <= 1'b1;
        else if (wr_irq && wdata[14])
            irq_sts <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pd_en <= 1'b0;
        else if (wr_misc)
            pd_en <= wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            cause <= 2'b00;
        else if (expire || sw_req)
            cause <= {expire, sw_req};
    end

    // R2
    ctl_lock_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_lk |=> $stable({ctl.wait_off, ctl.dbg, ctl.susp}));

    // R3
    en_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && ctl.tout_assert) |=> (ctl.en && ctl.tout_assert));

    // R6
    sts_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_sts) |-> $past(hit && irq_en));

    // R8
    irq_lock_chk: assert property (@(posedge clk) disable iff (rst)
        irq_lk |=> $stable({irq_en, pre_val}));

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int            CW      = 8,
    parameter logic [CW-1:0] PRE_DEF = 8'd4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_i,
    input  logic              halt_i,
    output logic              irq_o,
    output logic              rst_req_o
);

    reg_sel_e      sel;
    logic          wr_ctl, wr_svc, wr_irq, wr_misc;
    ctl_t          ctl;
    logic          sw_req, irq_en, irq_sts, pd_en;
    logic [CW-1:0] pre_val;
    logic [1:0]    cause;
    logic          key_reload, en_load, load, run, hit, expire;
    logic [CW-1:0] load_val;
    logic          req_q;

    assign sel     = decode(bus_addr);
    assign wr_ctl  = bus_we && (sel == SEL_CTL);
    assign wr_svc  = bus_we && (sel == SEL_SVC);
    assign wr_irq  = bus_we && (sel == SEL_IRQ);
    assign wr_misc = bus_we && (sel == SEL_MISC);

    kwdt_regs #(.CW(CW), .PRE_DEF(PRE_DEF)) i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_ctl  (wr_ctl),
        .wr_irq  (wr_irq),
        .wr_misc (wr_misc),
        .wdata   (bus_wdata),
        .hit     (hit),
        .expire  (expire),
        .ctl     (ctl),
        .sw_req  (sw_req),
        .irq_en  (irq_en),
        .irq_sts (irq_sts),
        .pre_val (pre_val),
        .pd_en   (pd_en),
        .cause   (cause)
    );

    kwdt_keyseq i_keys (
        .clk    (clk),
        .rst    (rst),
        .svc_wr (wr_svc),
        .wdata  (bus_wdata),
        .reload (key_reload)
    );

    // enabling loads with the timeout written in that same access
    assign en_load  = wr_ctl && !ctl.en && bus_wdata[2];
    assign load     = en_load || key_reload;
    assign load_val = wr_ctl ? bus_wdata[15:8] : ctl.wt;
    assign run      = ctl.en && !(ctl.susp && halt_i);

    kwdt_count #(.CW(CW)) i_count (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .run      (run),
        .tick     (tick_i),
        .pre_val  (pre_val),
        .hit      (hit),
        .expire   (expire)
    );

    always_ff @(posedge clk) begin
        if (rst)
            req_q <= 1'b0;
        else
            req_q <= expire || sw_req;
    end

    assign rst_req_o = req_q;
    assign irq_o     = irq_sts && irq_en;

    always_comb begin
        case (sel)
            SEL_CTL:   bus_rdata = {ctl.wt, ctl.wait_off, 1'b0, ctl.assert_out,
                                    1'b1, ctl.tout_assert, ctl.en, ctl.dbg,
                                    ctl.susp};
            SEL_CAUSE: bus_rdata = {14'b0, cause};
            SEL_IRQ:   bus_rdata = {irq_en, irq_sts, {(14-CW){1'b0}}, pre_val};
            SEL_MISC:  bus_rdata = {15'b0, pd_en};
            default:   bus_rdata = '0;
        endcase
    end

    // R9
    req_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |-> (cause != 2'b00));

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(hit));

endmodule

// File: tb/test_kwdt_top.sv
`timescale 1ns/1ps
module test_kwdt_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tick_i = 1'b0;
    logic        halt_i = 1'b0;
    logic        irq_o;
    logic        rst_req_o;

    int compared = 0;
    int mismatched = 0;
    int req_cnt = 0;

    always #2 clk = ~clk;

    kwdt_top i_kwdt_top (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_i    (tick_i),
        .halt_i    (halt_i),
        .irq_o     (irq_o),
        .rst_req_o (rst_req_o)
    );

    always @(negedge clk) if (!rst && rst_req_o) req_cnt++;

    // {address, write data, expected read-back}
    localparam logic [35:0] VEC [8] = '{
        {4'h8, 16'h0001, 16'h0001},   // R11 store
        {4'h8, 16'hFFFE, 16'h0000},   // R11 upper bits read 0
        {4'h2, 16'h1234, 16'h0000},   // R1 service reads 0
        {4'hA, 16'hFFFF, 16'h0000},   // R1 unmapped
        {4'h0, 16'hA5B2, 16'hA5B2},   // R2 first control write
        {4'h0, 16'h3C31, 16'h3CB2},   // R2 locked bits keep first value
        {4'h6, 16'h0007, 16'h0007},   // R8 first interrupt-control write
        {4'h6, 16'h80FF, 16'h0007}    // R8 locked
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        req_cnt = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
        end
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [15:0] v;

        do_reset();
        rd(4'h0, v); check("R1 ctl reset", v, 16'h0030);
        rd(4'h6, v); check("R1 irq reset", v, 16'h0004);
        rd(4'h4, v); check("R1 cause reset", v, 16'h0000);
        rd(4'h8, v); check("R1 misc reset", v, 16'h0000);
        check("R1 outputs reset", {14'b0, irq_o, rst_req_o}, 16'h0000);
        ticks(10);
        check("R10 disabled ignores ticks", 16'(req_cnt), 16'd0);

        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][35:32], VEC[i][31:16]);
            rd(VEC[i][35:32], v);
            check("R1/R2/R8/R11 vector", v, VEC[i][15:0]);
        end

        // R3 sticky bits; timeout field stays writable
        do_reset();
        wr(4'h0, 16'h003C);
        wr(4'h0, 16'h0730);
        rd(4'h0, v); check("R3 enable/tout-assert sticky", v, 16'h073C);

        // R4 expiry after T+1 ticks
        do_reset();
        wr(4'h0, 16'h0334);
        ticks(3);
        check("R4 no request before T+1", 16'(req_cnt), 16'd0);
        ticks(1);
        check("R4 request at T+1", 16'(req_cnt), 16'd1);
        rd(4'h4, v); check("R4 cause timeout", v, 16'h0002);
        ticks(3);
        check("R4 reload after expiry", 16'(req_cnt), 16'd1);
        ticks(1);
        check("R4 second expiry", 16'(req_cnt), 16'd2);

        // R5 key sequence
        do_reset();
        wr(4'h0, 16'h0334);
        ticks(3);
        wr(4'h2, 16'h5555);
        wr(4'h2, 16'hAAAA);
        ticks(3);
        check("R5 key reload", 16'(req_cnt), 16'd0);
        ticks(1);
        check("R5 expiry after key reload", 16'(req_cnt), 16'd1);
        ticks(3);
        wr(4'h2, 16'h5555);
        wr(4'h2, 16'h1234);
        wr(4'h2, 16'hAAAA);
        ticks(1);
        check("R5 broken sequence no reload", 16'(req_cnt), 16'd2);

        // R6/R7/R8 pretimeout
        do_reset();
        wr(4'h6, 16'h8002);
        wr(4'h0, 16'h0534);
        ticks(3);
        check("R6 no irq early", {15'b0, irq_o}, 16'h0000);
        ticks(1);
        check("R6 irq at pretimeout", {15'b0, irq_o}, 16'h0001);
        rd(4'h6, v); check("R6 status set", v, 16'hC002);
        wr(4'h6, 16'h0000);
        rd(4'h6, v); check("R7 write 0 keeps status", v, 16'hC002);
        wr(4'h6, 16'h4000);
        rd(4'h6, v); check("R7/R8 clear, lock holds", v, 16'h8002);
        check("R7 irq low after clear", {15'b0, irq_o}, 16'h0000);

        // R6 disabled interrupt never sets status
        do_reset();
        wr(4'h6, 16'h0002);
        wr(4'h0, 16'h0534);
        ticks(4);
        rd(4'h6, v); check("R6 disabled no status", v, 16'h0002);

        // R9 software reset
        do_reset();
        wr(4'h0, 16'h0020);
        check("R9 sw request", 16'(req_cnt), 16'd1);
        rd(4'h4, v); check("R9 cause software", v, 16'h0001);
        rd(4'h0, v); check("R9 bit4 reads 1", v, 16'h0030);

        // R10 suspend with halt
        do_reset();
        wr(4'h0, 16'h0135);
        halt_i = 1'b1;
        ticks(5);
        check("R10 suspended holds", 16'(req_cnt), 16'd0);
        halt_i = 1'b0;
        ticks(1);
        check("R10 resumes", 16'(req_cnt), 16'd0);
        ticks(1);
        check("R10 expiry after resume", 16'(req_cnt), 16'd1);
        wr(4'h0, 16'h0134);
        rd(4'h0, v); check("R2 suspend locked", v, 16'h0135);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule